// File: doc/BRIEF.md
# Toggle-Handshake Signed Divider

This unit divides one signed integer by another for a generated controller state machine. The controller puts the dividend and divisor on the operand inputs and then inverts its request toggle. The unit answers on the next clock edge. It copies the new toggle value into its acknowledge toggle and raises a one-cycle done flag. On the edge after that, it writes the quotient and remainder registers and drops done.

Because a request is signalled by the two toggles differing, no pulse has to be timed. A controller can see that a request is outstanding by comparing its own toggle with the acknowledge output. The divide itself is combinational. It is evaluated only in the cycle where done is high, so the operands must be held until that cycle.

Top module: `tgl_sdiv_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `ack_tgl_o`, `done_o`, `quot_o` and `rem_o` all become 0.
- R2: At an edge where `done_o` is 0 and `req_tgl_i` equals `ack_tgl_o`, no output changes, whatever the operand inputs carry.
- R3: At an edge where `done_o` is 0 and `req_tgl_i` differs from `ack_tgl_o`, `ack_tgl_o` takes the value of `req_tgl_i` and `done_o` becomes 1. `quot_o` and `rem_o` keep their values.
- R4: At an edge where `done_o` is 1, `done_o` becomes 0. At the same edge, `quot_o` and `rem_o` are loaded from the quotient and remainder of the operands present in that cycle.
- R5: The quotient is truncated toward zero. The remainder has the sign of the dividend, or is 0. For a nonzero divisor, quotient times divisor plus remainder equals the dividend, modulo 2^WIDTH.
- R6: A zero divisor gives a quotient of 0 and a remainder equal to the dividend.
- R7: The most negative dividend divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R8: A toggle of `req_tgl_i` seen while `done_o` is 1 is not acknowledged at that edge: `ack_tgl_o` keeps its value. The toggle is accepted at the following edge.
- R9: Operand values present only in the accept cycle, and changed before the done cycle, have no effect on the result.
- R10: `done_o` is never 1 on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| dvd_i | input | WIDTH | Dividend, two's complement |
| dvs_i | input | WIDTH | Divisor, two's complement |
| req_tgl_i | input | 1 | Request toggle; inverting it asks for a division |
| ack_tgl_o | output | 1 | Acknowledge toggle; equals the last accepted request toggle |
| done_o | output | 1 | High for the one cycle between acceptance and the result write |
| quot_o | output | WIDTH | Quotient register |
| rem_o | output | WIDTH | Remainder register |

## Verification
A corrupted acknowledge toggle shows at the ports on the next edge. The unit either starts a phantom division, marked by `done_o` rising with no toggle from the controller, or ignores a real request, so that `done_o` stays low one edge after the toggle. A stuck or doubled done phase shows within one further cycle as `done_o` high twice in a row, or as result registers that change while the unit is idle. A wrong divide path shows only in `quot_o` and `rem_o`, and only one cycle after done. The bench therefore compares the results against an independent magnitude-based model after every request. It adds directed cases for a zero divisor, the overflow pair and every sign combination.

// File: rtl/tsd_pkg.sv
// Package: shared width default and phase encoding for the toggle divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tsd_pkg;

    // Default operand and result width.
    localparam int unsigned TSD_W_DEF = 32;

    // Phase of the handshake decoded from the toggles and the done flag.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_ACCEPT = 2'b01,
        PH_EMIT   = 2'b10
    } tsd_phase_e;

endpackage

// File: rtl/tsd_hs_ctrl.sv
// Module: tsd_hs_ctrl
// Holds the acknowledge toggle and the done flag. A pending request exists
// while the request toggle differs from the acknowledge toggle. Emission
// (done high) has priority over accepting a new request.
// Assumes: the request toggle is synchronous to clk.
module tsd_hs_ctrl
    import tsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_tgl_i,
    output logic ack_tgl_o,
    output logic done_o,
    output logic load_o
);

    tsd_phase_e phase;

    // Decode the handshake phase; the three phases are mutually exclusive.
    always_comb begin
        if (done_o)
            phase = PH_EMIT;
        else if (req_tgl_i != ack_tgl_o)
            phase = PH_ACCEPT;
        else
            phase = PH_IDLE;
    end

    // Advance the toggle and done state on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_tgl_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            case (phase)
                PH_ACCEPT: begin
                    ack_tgl_o <= req_tgl_i;
                    done_o    <= 1'b1;
                end
                PH_EMIT:   done_o <= 1'b0;
                default:   ;
            endcase
        end
    end

    // Tell the result registers to load during the emit phase.
    assign load_o = (phase == PH_EMIT);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && (req_tgl_i == ack_tgl_o)) |=> ($stable(ack_tgl_o) && !done_o));

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && (req_tgl_i != ack_tgl_o)) |=> (done_o && (ack_tgl_o == $past(req_tgl_i))));

    p_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(ack_tgl_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/tsd_sdiv_core.sv
// Module: tsd_sdiv_core
// Combinational signed divide. The quotient is truncated toward zero and the
// remainder takes the sign of the dividend. A zero divisor gives quotient 0
// and remainder equal to the dividend. The most negative value divided by -1
// gives quotient wrapped to the most negative value and remainder 0.
// Assumes: the caller samples the outputs only when it needs them.
module tsd_sdiv_core #(
    parameter int unsigned WIDTH = tsd_pkg::TSD_W_DEF
) (
    input  logic [WIDTH-1:0] dvd_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH-1:0] quot_o,
    output logic [WIDTH-1:0] rem_o
);

    localparam logic [WIDTH-1:0] MOST_NEG  = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MINUS_ONE = {WIDTH{1'b1}};

    logic by_zero;
    logic ovf_pair;
    logic signed [WIDTH-1:0] s_dvd;
    logic signed [WIDTH-1:0] s_dvs;

    // Flag the two operand pairs the plain operators do not cover.
    always_comb begin
        by_zero  = (dvs_i == '0);
        ovf_pair = (dvd_i == MOST_NEG) && (dvs_i == MINUS_ONE);
        s_dvd    = signed'(dvd_i);
        s_dvs    = signed'(dvs_i);
    end

    // Select the result for the special cases or the general signed divide.
    always_comb begin
        if (by_zero) begin
            quot_o = '0;
            rem_o  = dvd_i;
        end else if (ovf_pair) begin
            quot_o = MOST_NEG;
            rem_o  = '0;
        end else begin
            quot_o = unsigned'(s_dvd / s_dvs);
            rem_o  = unsigned'(s_dvd % s_dvs);
        end
    end

    // Check the division identity and the remainder sign on every evaluation.
    always_comb begin
        if (!by_zero) begin
            p_identity_r5: assert (WIDTH'(quot_o * dvs_i + rem_o) == dvd_i);
            p_rem_sign_r5: assert ((rem_o == '0) || (rem_o[WIDTH-1] == dvd_i[WIDTH-1]));
        end
    end

endmodule

// File: rtl/tsd_result_reg.sv
// Module: tsd_result_reg
// Quotient and remainder registers, loaded only when the handshake
// controller signals the emit phase.
// Assumes: load_i is high for at most one cycle per request.
module tsd_result_reg #(
    parameter int unsigned WIDTH = tsd_pkg::TSD_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] quot_d_i,
    input  logic [WIDTH-1:0] rem_d_i,
    output logic [WIDTH-1:0] quot_o,
    output logic [WIDTH-1:0] rem_o
);

    // Capture the divide result on load; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_o <= '0;
            rem_o  <= '0;
        end else if (load_i) begin
            quot_o <= quot_d_i;
            rem_o  <= rem_d_i;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(quot_o) && $stable(rem_o)));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ((quot_o == $past(quot_d_i)) && (rem_o == $past(rem_d_i))));

endmodule

// File: rtl/tsd_unit_top.sv
// Module: tgl_sdiv_unit
// Top of the toggle-handshake signed divider. It joins the handshake
// controller, the combinational divide and the result registers.
// Assumes: the controller holds the operands stable up to the done cycle.
module tgl_sdiv_unit #(
    parameter int unsigned WIDTH = tsd_pkg::TSD_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dvd_i,
    input  logic [WIDTH-1:0] dvs_i,
    input  logic             req_tgl_i,
    output logic             ack_tgl_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quot_o,
    output logic [WIDTH-1:0] rem_o
);

    logic             load;
    logic [WIDTH-1:0] quot_d;
    logic [WIDTH-1:0] rem_d;

    tsd_hs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_tgl_i (req_tgl_i),
        .ack_tgl_o (ack_tgl_o),
        .done_o    (done_o),
        .load_o    (load)
    );

    tsd_sdiv_core #(.WIDTH(WIDTH)) u_core (
        .dvd_i  (dvd_i),
        .dvs_i  (dvs_i),
        .quot_o (quot_d),
        .rem_o  (rem_d)
    );

    tsd_result_reg #(.WIDTH(WIDTH)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .quot_d_i (quot_d),
        .rem_d_i  (rem_d),
        .quot_o   (quot_o),
        .rem_o    (rem_o)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!ack_tgl_o && !done_o && (quot_o == '0) && (rem_o == '0)));

endmodule

// File: tb/tgl_sdiv_unit_bench.sv
// Bench for tgl_sdiv_unit: directed corner cases plus seeded random divisions.
// Inputs are driven at the falling edge; outputs are sampled there as well.
module tgl_sdiv_unit_bench;

    localparam int W = 32;
    localparam logic [W-1:0] MNEG = 32'h8000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] dvd = '0;
    logic [W-1:0] dvs = '0;
    logic         req = 1'b0;
    logic         ack;
    logic         done;
    logic [W-1:0] quot;
    logic [W-1:0] rem;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tgl_sdiv_unit #(.WIDTH(W)) u_tgl_sdiv_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .dvd_i     (dvd),
        .dvs_i     (dvs),
        .req_tgl_i (req),
        .ack_tgl_o (ack),
        .done_o    (done),
        .quot_o    (quot),
        .rem_o     (rem)
    );

    // Count one comparison and report a mismatch.
    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: divide the magnitudes, then restore the signs.
    function automatic logic [2*W-1:0] ref_div(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0]   ma;
        logic [W:0]   mb;
        logic [W:0]   uq;
        logic [W:0]   ur;
        logic [W-1:0] q;
        logic [W-1:0] r;
        if (b == '0) begin
            q = '0;
            r = a;
        end else begin
            ma = a[W-1] ? ({1'b0, ~a} + 1'b1) : {1'b0, a};
            mb = b[W-1] ? ({1'b0, ~b} + 1'b1) : {1'b0, b};
            uq = ma / mb;
            ur = ma % mb;
            q  = (a[W-1] ^ b[W-1]) ? W'(~uq + 1'b1) : uq[W-1:0];
            r  = a[W-1] ? W'(~ur + 1'b1) : ur[W-1:0];
        end
        return {q, r};
    endfunction

    // Wait one rising edge; return at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Full request: toggle, check the accept cycle (R3), then the result (R4).
    task automatic divide(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        logic [2*W-1:0] e;
        logic [W-1:0]   q0;
        logic [W-1:0]   r0;
        q0  = quot;
        r0  = rem;
        dvd = a;
        dvs = b;
        req = ~req;
        step();
        chk("R3 done set", {31'd0, done}, 32'd1);
        chk("R3 ack follows req", {31'd0, ack}, {31'd0, req});
        chk("R3 quot held", quot, q0);
        chk("R3 rem held", rem, r0);
        step();
        e = ref_div(a, b);
        chk("R4 R10 done cleared", {31'd0, done}, 32'd0);
        chk({tag, " quot"}, quot, e[2*W-1:W]);
        chk({tag, " rem"}, rem, e[W-1:0]);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2*W-1:0] e;
        logic [W-1:0]   q0;
        logic [W-1:0]   r0;
        int unsigned    seed_dummy;
        seed_dummy = $urandom(32'd20240611);

        // R1: reset state
        dvd = 32'd55;
        dvs = 32'd5;
        req = 1'b1;
        @(negedge clk);
        step();
        step();
        chk("R1 ack", {31'd0, ack}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 quot", quot, 32'd0);
        chk("R1 rem", rem, 32'd0);
        req = 1'b0;
        rst_n = 1'b1;
        step();

        // R2: idle with wandering operands leaves everything untouched
        for (int i = 0; i < 6; i++) begin
            dvd = $urandom;
            dvs = $urandom;
            step();
            chk("R2 idle done", {31'd0, done}, 32'd0);
            chk("R2 idle ack", {31'd0, ack}, 32'd0);
            chk("R2 idle quot", quot, 32'd0);
            chk("R2 idle rem", rem, 32'd0);
        end

        // R5: every sign combination
        divide(32'd17, 32'd5, "R5 pos/pos");
        chk("R5 17/5 q", quot, 32'd3);
        divide(-32'sd17, 32'd5, "R5 neg/pos");
        chk("R5 -17/5 q", quot, -32'sd3);
        chk("R5 -17/5 r", rem, -32'sd2);
        divide(32'd17, -32'sd5, "R5 pos/neg");
        chk("R5 17/-5 r", rem, 32'd2);
        divide(-32'sd17, -32'sd5, "R5 neg/neg");
        chk("R5 -17/-5 q", quot, 32'd3);

        // R6: zero divisor
        divide(32'hDEAD_BEEF, 32'd0, "R6 zero divisor");
        chk("R6 q zero", quot, 32'd0);
        chk("R6 r dividend", rem, 32'hDEAD_BEEF);

        // R7: overflow pair
        divide(MNEG, 32'hFFFF_FFFF, "R7 overflow");
        chk("R7 q wraps", quot, MNEG);
        chk("R7 r zero", rem, 32'd0);

        // R2 again: idle after a result keeps it
        q0 = quot;
        r0 = rem;
        dvd = 32'd999;
        dvs = 32'd3;
        step();
        step();
        chk("R2 result held quot", quot, q0);
        chk("R2 result held rem", rem, r0);

        // R9: operands changed between accept and done cycles
        dvd = 32'd100;
        dvs = 32'd7;
        req = ~req;
        step();
        chk("R9 accept done", {31'd0, done}, 32'd1);
        dvd = -32'sd50;
        dvs = 32'd3;
        step();
        chk("R9 quot from done-cycle operands", quot, -32'sd16);
        chk("R9 rem from done-cycle operands", rem, -32'sd2);

        // R8: toggle during the done cycle is deferred by one edge
        dvd = 32'd40;
        dvs = 32'd6;
        req = ~req;
        step();
        chk("R8 first accept", {31'd0, done}, 32'd1);
        req = ~req;
        step();
        chk("R8 ack not taken in emit", {31'd0, ack}, {31'd0, ~req});
        chk("R8 done low after emit", {31'd0, done}, 32'd0);
        chk("R8 first result", quot, 32'd6);
        step();
        chk("R8 deferred accept done", {31'd0, done}, 32'd1);
        chk("R8 deferred accept ack", {31'd0, ack}, {31'd0, req});
        dvd = 32'd41;
        dvs = 32'd6;
        step();
        chk("R8 R10 done cleared", {31'd0, done}, 32'd0);
        chk("R8 second result rem", rem, 32'd5);

        // Random divisions; half use small divisors to get large quotients
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = $urandom;
            b = $urandom;
            if (i % 2 == 0) b = W'($signed(b) >>> ($urandom % 31));
            if (i % 17 == 0) b = '0;
            if (i % 23 == 0) a = MNEG;
            divide(a, b, "R5 random");
            e = ref_div(a, b);
            chk("R4 random quot recheck", quot, e[2*W-1:W]);
        end

        // R1: reset after activity clears everything
        rst_n = 1'b0;
        step();
        chk("R1 late ack", {31'd0, ack}, 32'd0);
        chk("R1 late quot", quot, 32'd0);
        chk("R1 late rem", rem, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule